// File: doc/BRIEF.md
# Execute-Stage Poison and Redirect Unit

This block is the control slice of a pipelined processor's execute stage. It holds the one authoritative execute epoch bit and compares it against the epoch tag that each arriving instruction carries. An instruction whose tag has gone stale belongs to a squashed path. It is poisoned: it still takes a slot toward commit, but that slot can no longer write a register, and it has no other effect.

A live instruction keeps its destination write. If its resolved next pc disagrees with the prediction (flagged by the external ALU), the unit flips the epoch so that every younger wrong-path instruction is poisoned in turn. Every live control instruction (branch, jump or jump-register) also queues a message toward fetch. The message holds the pc, the resolved next pc, the taken and mispredict flags and the control kind. Fetch uses it to train its predictors, and to redirect when the mispredict flag is set.

Messages wait in a small queue. When that queue is full, a live control instruction stalls at the input until space frees up. Arithmetic, memory access and predictor tables live outside this block.

Top module: `exec_poison_unit`

## Requirements
- R1: After reset the epoch is 0, no message is pending, and with no input presented `cmtValid` is 0 and `inReady` is 1.
- R2: An instruction whose `inEpoch` differs from the current epoch is poisoned. It still yields `cmtValid`=1, but `cmtDstValid`=0.
- R3: A live instruction (tag equal to the epoch) passes `inDstValid`, `inDst` and `inData` unchanged to the commit outputs, in the same cycle.
- R4: A live instruction with `inMispred`=1 inverts the epoch on the clock edge that accepts it. This holds for any kind.
- R5: A live instruction whose `inKind` is branch (1), jump (2) or jump-register (3) queues a message with the pc, next pc, taken, mispredict and kind fields. The message is visible at the queue head from the cycle after acceptance, and messages leave in arrival order.
- R6: A poisoned instruction queues no message and leaves the epoch unchanged, whatever its mispredict flag.
- R7: An instruction of kind other (0) never queues a message.
- R8: The message queue holds `MSG_DEPTH` entries (default 2). While it is full, a live control instruction sees `inReady`=0 and `cmtValid`=0. A non-control instruction is still accepted while the queue is full.
- R9: With `cmtReady`=0 no instruction is accepted (`inReady`=0), and the epoch and the queue stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An instruction result is presented |
| inReady | output | 1 | The presented result is taken on this edge (when inValid is 1) |
| inEpoch | input | 1 | Epoch tag carried by the instruction |
| inKind | input | 2 | 0 other, 1 branch, 2 jump, 3 jump-register |
| inMispred | input | 1 | Resolved next pc differs from the prediction |
| inTaken | input | 1 | Branch-taken flag |
| inPc | input | XLEN | Instruction pc |
| inNextPc | input | XLEN | Resolved next pc |
| inDstValid | input | 1 | Instruction writes a register |
| inDst | input | REGW | Destination register index |
| inData | input | XLEN | Result data |
| cmtValid | output | 1 | Commit slot offered |
| cmtReady | input | 1 | Commit side accepts the slot |
| cmtDstValid | output | 1 | Slot carries a real register write |
| cmtDst | output | REGW | Destination index |
| cmtData | output | XLEN | Write data |
| msgValid | output | 1 | Message available at queue head |
| msgReady | input | 1 | Fetch consumes the head message |
| msgKind | output | 2 | Control kind of the message |
| msgMispred | output | 1 | Redirect required |
| msgTaken | output | 1 | Taken flag |
| msgPc | output | XLEN | pc of the control instruction |
| msgNextPc | output | XLEN | Resolved next pc |
| epochOut | output | 1 | Current execute epoch |

## Verification
The commit outputs and `inReady` are combinational from the inputs. The bench drives each packet on a falling edge and reads them 1 ns later, before the accepting rising edge. The epoch and the queued message both change on the accepting edge, so the bench reads them at the falling edge that follows, one cycle after the stimulus. Each row reads the message there before the next rising edge pops it. In the full-queue and backpressure tests, the bench also waits until after the edge on which nothing should have changed before it checks the epoch and the queue head.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER  = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_JUMP   = 2'd2,
    KIND_JREG   = 2'd3
  } instKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic poison;
    logic flipEpoch;
    logic pushMsg;
  } exStrobe_t;
endpackage

// File: rtl/exu_msg_fifo.sv
module exu_msg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPop;

  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = store[rdPtr];
  assign doPop    = pop && notEmpty;

  always_ff @(posedge clk) begin
    if (push && !full) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push && !full) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)         rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push && !full, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: control never pushes into a full queue
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R8: occupancy stays within depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  // R5: a push into an empty queue is visible next cycle
  a_r5_push_visible: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> notEmpty);
endmodule

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inEpoch,
  input  logic      inMispred,
  input  logic [1:0] inKind,
  input  logic      cmtReady,
  input  logic      msgFull,
  output logic      inReady,
  output logic      cmtValid,
  output logic      epoch,
  output exStrobe_t strobe
);
  logic epochQ;
  logic isCtrl, stale, stallMsg, fire;

  assign isCtrl   = (inKind != KIND_OTHER);
  assign stale    = (inEpoch != epochQ);
  assign stallMsg = isCtrl && !stale && msgFull;
  assign cmtValid = inValid && !stallMsg;
  assign inReady  = cmtReady && !stallMsg;
  assign fire     = cmtValid && cmtReady;

  always_comb begin
    strobe.fire      = fire;
    strobe.poison    = inValid && stale;
    strobe.flipEpoch = fire && !stale && inMispred;
    strobe.pushMsg   = fire && !stale && isCtrl;
  end

  always_ff @(posedge clk) begin
    if (rst)                   epochQ <= 1'b0;
    else if (strobe.flipEpoch) epochQ <= ~epochQ;
  end

  assign epoch = epochQ;

  // R1: epoch is zero right after reset
  a_r1_epoch_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (epochQ == 1'b0));
  // R4: a live mispredicted instruction inverts the epoch
  a_r4_flip: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && (inEpoch == epochQ) && inMispred) |=> (epochQ != $past(epochQ)));
  // R6: a poisoned instruction leaves the epoch alone
  a_r6_epoch_hold: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && (inEpoch != epochQ)) |=> $stable(epochQ));
  // R9: no acceptance without commit space
  a_r9_backpressure: assert property (@(posedge clk) disable iff (rst)
    !cmtReady |-> !inReady);
endmodule

// File: rtl/exu_dpath.sv
module exu_dpath
  import exu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REGW      = 5,
  parameter int MSG_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  exStrobe_t       strobe,
  input  logic [1:0]      inKind,
  input  logic            inMispred,
  input  logic            inTaken,
  input  logic [XLEN-1:0] inPc,
  input  logic [XLEN-1:0] inNextPc,
  input  logic            inDstValid,
  input  logic [REGW-1:0] inDst,
  input  logic [XLEN-1:0] inData,
  input  logic            msgReady,
  output logic            cmtDstValid,
  output logic [REGW-1:0] cmtDst,
  output logic [XLEN-1:0] cmtData,
  output logic            msgFull,
  output logic            msgValid,
  output logic [1:0]      msgKind,
  output logic            msgMispred,
  output logic            msgTaken,
  output logic [XLEN-1:0] msgPc,
  output logic [XLEN-1:0] msgNextPc
);
  localparam int MSG_W = 2 * XLEN + 4;

  logic [MSG_W-1:0] packed_in, packed_head;

  assign cmtDstValid = inDstValid && !strobe.poison;
  assign cmtDst      = inDst;
  assign cmtData     = inData;

  assign packed_in = {inKind, inMispred, inTaken, inPc, inNextPc};

  exu_msg_fifo #(.WIDTH(MSG_W), .DEPTH(MSG_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (strobe.pushMsg),
    .pushData (packed_in),
    .pop      (msgReady),
    .headData (packed_head),
    .notEmpty (msgValid),
    .full     (msgFull)
  );

  assign {msgKind, msgMispred, msgTaken, msgPc, msgNextPc} = packed_head;

  // R2: a poisoned slot never carries a register write
  a_r2_poison_no_write: assert property (@(posedge clk) disable iff (rst)
    strobe.poison |-> !cmtDstValid);
  // R7: non-control instructions never enter the queue
  a_r7_no_msg_other: assert property (@(posedge clk) disable iff (rst)
    strobe.pushMsg |-> (inKind != KIND_OTHER));
endmodule

// File: rtl/exec_poison_unit.sv
module exec_poison_unit
  import exu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REGW      = 5,
  parameter int MSG_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic            inReady,
  input  logic            inEpoch,
  input  logic [1:0]      inKind,
  input  logic            inMispred,
  input  logic            inTaken,
  input  logic [XLEN-1:0] inPc,
  input  logic [XLEN-1:0] inNextPc,
  input  logic            inDstValid,
  input  logic [REGW-1:0] inDst,
  input  logic [XLEN-1:0] inData,
  output logic            cmtValid,
  input  logic            cmtReady,
  output logic            cmtDstValid,
  output logic [REGW-1:0] cmtDst,
  output logic [XLEN-1:0] cmtData,
  output logic            msgValid,
  input  logic            msgReady,
  output logic [1:0]      msgKind,
  output logic            msgMispred,
  output logic            msgTaken,
  output logic [XLEN-1:0] msgPc,
  output logic [XLEN-1:0] msgNextPc,
  output logic            epochOut
);
  exStrobe_t strobe;
  logic msgFull;

  exu_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inEpoch  (inEpoch),
    .inMispred(inMispred),
    .inKind   (inKind),
    .cmtReady (cmtReady),
    .msgFull  (msgFull),
    .inReady  (inReady),
    .cmtValid (cmtValid),
    .epoch    (epochOut),
    .strobe   (strobe)
  );

  exu_dpath #(.XLEN(XLEN), .REGW(REGW), .MSG_DEPTH(MSG_DEPTH)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .inKind     (inKind),
    .inMispred  (inMispred),
    .inTaken    (inTaken),
    .inPc       (inPc),
    .inNextPc   (inNextPc),
    .inDstValid (inDstValid),
    .inDst      (inDst),
    .inData     (inData),
    .msgReady   (msgReady),
    .cmtDstValid(cmtDstValid),
    .cmtDst     (cmtDst),
    .cmtData    (cmtData),
    .msgFull    (msgFull),
    .msgValid   (msgValid),
    .msgKind    (msgKind),
    .msgMispred (msgMispred),
    .msgTaken   (msgTaken),
    .msgPc      (msgPc),
    .msgNextPc  (msgNextPc)
  );
endmodule

// File: tb/exec_poison_unit_tb.sv
module exec_poison_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 0, inEpoch = 0, inMispred = 0, inTaken = 0, inDstValid = 0;
  logic [1:0] inKind = 0;
  logic [31:0] inPc = 0, inNextPc = 0, inData = 0;
  logic [4:0] inDst = 0;
  logic cmtReady = 1, msgReady = 1;
  logic inReady, cmtValid, cmtDstValid, msgValid, msgMispred, msgTaken, epochOut;
  logic [4:0] cmtDst;
  logic [31:0] cmtData, msgPc, msgNextPc;
  logic [1:0] msgKind;

  int checks = 0;
  int errors = 0;
  logic mEp = 1'b0;

  always #5 clk = ~clk;

  exec_poison_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inEpoch(inEpoch),
    .inKind(inKind), .inMispred(inMispred), .inTaken(inTaken), .inPc(inPc),
    .inNextPc(inNextPc), .inDstValid(inDstValid), .inDst(inDst), .inData(inData),
    .cmtValid(cmtValid), .cmtReady(cmtReady), .cmtDstValid(cmtDstValid),
    .cmtDst(cmtDst), .cmtData(cmtData), .msgValid(msgValid), .msgReady(msgReady),
    .msgKind(msgKind), .msgMispred(msgMispred), .msgTaken(msgTaken),
    .msgPc(msgPc), .msgNextPc(msgNextPc), .epochOut(epochOut)
  );

  typedef struct packed {
    logic        tag;
    logic [1:0]  kind;
    logic        mis;
    logic        tk;
    logic        dv;
    logic [4:0]  dst;
    logic [31:0] pc;
    logic [31:0] npc;
    logic [31:0] data;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd5,  32'h1000, 32'h1004, 32'hA5A5_0001},
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 5'd0,  32'h1004, 32'h1040, 32'h0000_0000},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 5'd31, 32'h1040, 32'h2000, 32'h0000_1044},
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0,  32'h1044, 32'h1048, 32'h0000_0000},
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd7,  32'h1048, 32'h104C, 32'hDEAD_BEEF},
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 5'd0,  32'h2000, 32'h3000, 32'h0000_0000},
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 5'd9,  32'h3000, 32'h3004, 32'h1234_5678},
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0,  32'h3004, 32'h3008, 32'h0000_0000},
    '{1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 5'd3,  32'h3008, 32'h4000, 32'h0000_300C},
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 5'd4,  32'h3008, 32'h300C, 32'h0BAD_F00D}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input row_t r);
    inValid = 1'b1; inEpoch = r.tag; inKind = r.kind; inMispred = r.mis;
    inTaken = r.tk; inDstValid = r.dv; inDst = r.dst; inPc = r.pc;
    inNextPc = r.npc; inData = r.data;
  endtask

  task automatic ctrl_row(input logic [31:0] pc, input logic mis, output row_t r);
    r = '{mEp, 2'd1, mis, 1'b1, 1'b0, 5'd0, pc, pc + 32'h40, 32'h0};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    row_t r;
    logic poison, expMsg;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 epoch", epochOut, 0);
    chk("R1 msgValid", msgValid, 0);
    chk("R1 cmtValid", cmtValid, 0);
    chk("R1 inReady", inReady, 1);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      r = ROWS[i];
      @(negedge clk);
      apply(r);
      #1;
      poison = (r.tag != mEp);
      expMsg = !poison && (r.kind != 2'd0);
      chk("R2/R3 cmtValid", cmtValid, 1);
      chk(poison ? "R2 cmtDstValid" : "R3 cmtDstValid", cmtDstValid, poison ? 1'b0 : r.dv);
      if (!poison) begin
        chk("R3 cmtDst", cmtDst, r.dst);
        chk("R3 cmtData", cmtData, r.data);
      end
      @(posedge clk);
      if (!poison && r.mis) mEp = ~mEp;
      @(negedge clk);
      inValid = 1'b0;
      chk(poison ? "R6 epoch" : "R4 epoch", epochOut, mEp);
      chk(poison ? "R6 msgValid" : (r.kind == 2'd0 ? "R7 msgValid" : "R5 msgValid"), msgValid, expMsg);
      if (expMsg) begin
        chk("R5 msgPc", msgPc, r.pc);
        chk("R5 msgNextPc", msgNextPc, r.npc);
        chk("R5 msgTaken", msgTaken, r.tk);
        chk("R5 msgMispred", msgMispred, r.mis);
        chk("R5 msgKind", msgKind, r.kind);
      end
    end

    // R8: fill the queue, then stall a control instruction
    @(negedge clk);
    msgReady = 1'b0;
    ctrl_row(32'h5100, 1'b0, r); apply(r);
    @(negedge clk);
    ctrl_row(32'h5200, 1'b0, r); r.kind = 2'd2; apply(r);
    @(negedge clk);
    ctrl_row(32'h5300, 1'b0, r); apply(r);
    #1;
    chk("R8 inReady full", inReady, 0);
    chk("R8 cmtValid full", cmtValid, 0);
    inKind = 2'd0; inDstValid = 1'b1; inDst = 5'd12; inData = 32'h77;
    #1;
    chk("R8 inReady non-control", inReady, 1);
    chk("R8 cmtDstValid non-control", cmtDstValid, 1);
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 head first", msgPc, 32'h5100);
    msgReady = 1'b1;
    @(negedge clk);
    chk("R8 head second", msgPc, 32'h5200);
    chk("R8 head kind", msgKind, 2'd2);
    @(negedge clk);
    chk("R8 drained", msgValid, 0);

    // R9: commit backpressure
    cmtReady = 1'b0;
    ctrl_row(32'h6000, 1'b1, r); apply(r);
    #1;
    chk("R9 inReady", inReady, 0);
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 epoch hold", epochOut, mEp);
    chk("R9 no msg", msgValid, 0);
    cmtReady = 1'b1;

    // R7 and R4: non-control mispredict flips epoch, no message
    r = '{mEp, 2'd0, 1'b1, 1'b0, 1'b1, 5'd2, 32'h7000, 32'h7100, 32'h5};
    apply(r);
    @(posedge clk);
    mEp = ~mEp;
    @(negedge clk);
    inValid = 1'b0;
    chk("R4 epoch other-kind", epochOut, mEp);
    chk("R7 no msg", msgValid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule